// File: doc/BRIEF.md
# Edge-Latched Address Static RAM

This block models a small static memory of 256 words of 4 bits. A bus master starts an access by pulling the active-low enable strobe low. The address is captured into a register at that moment, and the row and column decoders turn on only from then. The access then runs on the held address until the strobe returns high. Two active-high select inputs and a write/read control choose what the access does. A write stores the incoming bus value at the held address. A read loads the stored word into an output latch and drives it onto the shared data bus.

The strobes are sampled by a fast system clock, so the falling edge is found by comparing each sample with the one before. The bidirectional data bus is split into an input, an output and an output-enable, and a pad ring can merge them. Data moves under the strobe protocol with no valid/ready handshake, and the block never applies back-pressure. The master owns the timing of every access. Stored words need no refresh and survive any length of idle time.

Top module: `edge_latched_sram`

## Requirements
- R1: Each of the 256 addresses holds its own 4-bit word. Writing all 256 and reading them back returns each written value.
- R2: The address splits into a 5-bit row index made of bits {7,6,5,1,0} and a 3-bit column-group index made of bits {4,3,2}. During an access exactly one row is decoded, and no row is decoded when the block is idle.
- R3: The address is captured at the first clock edge where `strobe_n` is sampled low after being sampled high. Changes on `addr` after that edge, within the same access, have no effect on the access.
- R4: A write is an access with `sel_a`=1, `sel_b`=1 and `wr_en`=1. It stores `bus_in` at the captured address, and `bus_oe` stays 0 throughout.
- R5: A read is an access with `sel_a`=1, `sel_b`=1 and `wr_en`=0. From the second clock edge after capture, `bus_oe`=1 and `bus_out` shows the stored word.
- R6: If either select is 0, `bus_oe` is 0 and a write attempt leaves memory unchanged.
- R7: The output latch holds the last word it read. After the strobe rises, `bus_oe` drops to 0 while `bus_out` keeps that word.
- R8: After reset, `bus_oe` is 0. A strobe already low when reset is released starts no access until it has been sampled high.
- R9: Stored contents persist across an arbitrary idle period with the strobe high, even while the address toggles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the strobes |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_n | input | 1 | Active-low enable strobe; its falling edge captures the address |
| sel_a | input | 1 | First chip select, active high |
| sel_b | input | 1 | Second chip select, active high |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Word address |
| bus_in | input | 4 | Incoming half of the shared data bus |
| bus_out | output | 4 | Outgoing half of the shared data bus (output latch) |
| bus_oe | output | 1 | Drive enable for the shared data bus |

## Verification
Two events land in one access cycle: the held address is being used by the array, and the master moves `addr` to a new value. Every access in the bench does exactly this. `addr` is inverted one cycle after capture, and the result is judged by the word read back, or by a later read of the intended and the disturbing location. A second overlap is a write attempted with one select low while other data sits in memory. It is judged by reading the location afterwards.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_READ  = 2'd2,
    ACC_NONE  = 2'd3
  } acc_kind_t;

  function automatic acc_kind_t classify(input logic active, input logic sa,
                                         input logic sb, input logic wr);
    if (!active)       return ACC_IDLE;
    else if (!(sa && sb)) return ACC_NONE;
    else if (wr)       return ACC_WRITE;
    else               return ACC_READ;
  endfunction
endpackage

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_n,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              active,
  output logic [ADDR_W-1:0] addr_q
);
  logic strobe_prev;
  logic fall;

  // strobe_prev resets low so a strobe held low through reset is not an edge
  assign fall = strobe_prev && !strobe_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_prev <= 1'b0;
      active      <= 1'b0;
      addr_q      <= '0;
    end else begin
      strobe_prev <= strobe_n;
      if (fall) begin
        active <= 1'b1;
        addr_q <= addr_in;
      end else if (strobe_n) begin
        active <= 1'b0;
      end
    end
  end

  assert_addr_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && $past(rst_n)) |-> $stable(addr_q));

  assert_strobe_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_n |=> !active);
endmodule

// File: rtl/sram_decode.sv
module sram_decode #(
  parameter int ROW_W   = 5,
  parameter int COL_W   = 3,
  parameter int COL_LSB = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     active,
  input  logic [ROW_W+COL_W-1:0]   addr_q,
  output logic [ROW_W-1:0]         row_idx,
  output logic [COL_W-1:0]         col_idx,
  output logic [(1<<ROW_W)-1:0]    row_sel
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int ROWS   = 1 << ROW_W;

  assign col_idx = addr_q[COL_LSB +: COL_W];
  assign row_idx = {addr_q[ADDR_W-1:COL_LSB+COL_W], addr_q[COL_LSB-1:0]};

  for (genvar r = 0; r < ROWS; r++) begin : g_row_dec
    assign row_sel[r] = active && (row_idx == ROW_W'(r));
  end

  assert_one_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ($countones(row_sel) == 1));

  assert_no_row_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (row_sel == '0));
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int ROW_W  = 5,
  parameter int COL_W  = 3,
  parameter int DATA_W = 4
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [(1<<ROW_W)-1:0] row_sel,
  input  logic [ROW_W-1:0]      row_idx,
  input  logic [COL_W-1:0]      col_idx,
  input  logic [DATA_W-1:0]     din,
  output logic [DATA_W-1:0]     rd_word
);
  localparam int ROWS     = 1 << ROW_W;
  localparam int ROW_BITS = (1 << COL_W) * DATA_W;

  logic [ROW_BITS-1:0] row_data [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [ROW_BITS-1:0] cells;
    always_ff @(posedge clk) begin
      if (we && row_sel[r])
        cells[col_idx*DATA_W +: DATA_W] <= din;
    end
    assign row_data[r] = cells;
  end

  always_comb begin
    rd_word = row_data[row_idx][col_idx*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/sram_out_latch.sv
module sram_out_latch #(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  assert_latch_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/edge_latched_sram.sv
module edge_latched_sram #(
  parameter int ROW_W   = 5,
  parameter int COL_W   = 3,
  parameter int COL_LSB = 2,
  parameter int DATA_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     strobe_n,
  input  logic                     sel_a,
  input  logic                     sel_b,
  input  logic                     wr_en,
  input  logic [ROW_W+COL_W-1:0]   addr,
  input  logic [DATA_W-1:0]        bus_in,
  output logic [DATA_W-1:0]        bus_out,
  output logic                     bus_oe
);
  import sram_pkg::*;

  localparam int ADDR_W = ROW_W + COL_W;
  localparam int ROWS   = 1 << ROW_W;

  logic              active;
  logic [ADDR_W-1:0] addr_q;
  logic [ROW_W-1:0]  row_idx;
  logic [COL_W-1:0]  col_idx;
  logic [ROWS-1:0]   row_sel;
  logic [DATA_W-1:0] rd_word;
  acc_kind_t         kind;
  logic              do_write;
  logic              do_read;

  assign kind     = classify(active, sel_a, sel_b, wr_en);
  assign do_write = (kind == ACC_WRITE);
  assign do_read  = (kind == ACC_READ);
  assign bus_oe   = do_read;

  sram_strobe_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .addr_in(addr),
    .active(active), .addr_q(addr_q)
  );

  sram_decode #(.ROW_W(ROW_W), .COL_W(COL_W), .COL_LSB(COL_LSB)) u_dec (
    .clk(clk), .rst_n(rst_n), .active(active), .addr_q(addr_q),
    .row_idx(row_idx), .col_idx(col_idx), .row_sel(row_sel)
  );

  sram_array #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .we(do_write), .row_sel(row_sel), .row_idx(row_idx),
    .col_idx(col_idx), .din(bus_in), .rd_word(rd_word)
  );

  sram_out_latch #(.DATA_W(DATA_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .load(do_read), .d(rd_word), .q(bus_out)
  );

  assert_no_drive_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !bus_oe);

  assert_deselect_floats_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_a || !sel_b) |-> !bus_oe);
endmodule

// File: tb/edge_latched_sram_bench.sv
module edge_latched_sram_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe_n = 1'b1;
  logic       sel_a = 1'b0;
  logic       sel_b = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] addr = '0;
  logic [3:0] bus_in = '0;
  logic [3:0] bus_out;
  logic       bus_oe;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  edge_latched_sram u_edge_latched_sram (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .sel_a(sel_a),
    .sel_b(sel_b), .wr_en(wr_en), .addr(addr), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe)
  );

  // {wr, sel_a, sel_b, addr[8], data[4], exp_oe, exp_data[4]}
  localparam int NV = 12;
  localparam logic [19:0] VEC [NV] = '{
    {1'b1, 1'b1, 1'b1, 8'h00, 4'h5, 1'b0, 4'h0},
    {1'b1, 1'b1, 1'b1, 8'hFF, 4'hA, 1'b0, 4'h0},
    {1'b1, 1'b1, 1'b1, 8'h21, 4'h3, 1'b0, 4'h0},
    {1'b0, 1'b1, 1'b1, 8'h00, 4'h0, 1'b1, 4'h5},
    {1'b0, 1'b1, 1'b1, 8'hFF, 4'h0, 1'b1, 4'hA},
    {1'b0, 1'b1, 1'b1, 8'h21, 4'h0, 1'b1, 4'h3},
    {1'b1, 1'b0, 1'b1, 8'h00, 4'h9, 1'b0, 4'h0},
    {1'b0, 1'b1, 1'b1, 8'h00, 4'h0, 1'b1, 4'h5},
    {1'b0, 1'b1, 1'b0, 8'hFF, 4'h0, 1'b0, 4'h0},
    {1'b1, 1'b1, 1'b1, 8'h84, 4'hC, 1'b0, 4'h0},
    {1'b0, 1'b1, 1'b1, 8'h84, 4'h0, 1'b1, 4'hC},
    {1'b0, 1'b1, 1'b1, 8'h21, 4'h0, 1'b1, 4'h3}
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One access; addr is disturbed one cycle after capture (R3).
  task automatic access(input logic wr, input logic sa, input logic sb,
                        input logic [7:0] a, input logic [3:0] d,
                        output logic oe, output logic [3:0] q);
    @(negedge clk);
    wr_en = wr; sel_a = sa; sel_b = sb; addr = a; bus_in = d; strobe_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    addr = ~a;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    oe = bus_oe; q = bus_out;
    strobe_n = 1'b1;
    @(posedge clk);
  endtask

  initial begin : watchdog
    #(5 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic       oe;
    logic [3:0] q;
    // R8: strobe low and read selects held through reset release
    strobe_n = 1'b0; sel_a = 1'b1; sel_b = 1'b1; wr_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 oe after reset", {3'b0, bus_oe}, 4'h0);
    check("R8 latch after reset", bus_out, 4'h0);
    strobe_n = 1'b1; sel_a = 1'b0; sel_b = 1'b0;
    @(posedge clk);

    // vector table: R4 R5 R6 R3
    for (int i = 0; i < NV; i++) begin
      access(VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16:9], VEC[i][8:5], oe, q);
      check($sformatf("R4/R5/R6 vec%0d oe", i), {3'b0, oe}, {3'b0, VEC[i][4]});
      if (VEC[i][4]) check($sformatf("R5/R3 vec%0d data", i), q, VEC[i][3:0]);
    end

    // R7: latch keeps last read word after strobe rises
    access(1'b0, 1'b1, 1'b1, 8'hFF, 4'h0, oe, q);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R7 oe released", {3'b0, bus_oe}, 4'h0);
    check("R7 latch holds", bus_out, 4'hA);

    // R3: disturbing address ~0x84 = 0x7B must be untouched by write to 0x84
    access(1'b1, 1'b1, 1'b1, 8'h7B, 4'h1, oe, q);
    access(1'b1, 1'b1, 1'b1, 8'h84, 4'hE, oe, q);
    access(1'b0, 1'b1, 1'b1, 8'h7B, 4'h0, oe, q);
    check("R3 disturbed addr unchanged", q, 4'h1);
    access(1'b0, 1'b1, 1'b1, 8'h84, 4'h0, oe, q);
    check("R3 captured addr written", q, 4'hE);

    // R9: persistence over a long idle period with address toggling
    access(1'b1, 1'b1, 1'b1, 8'h5A, 4'h6, oe, q);
    for (int c = 0; c < 500; c++) begin
      @(negedge clk);
      addr = 8'(c);
    end
    access(1'b0, 1'b1, 1'b1, 8'h5A, 4'h0, oe, q);
    check("R9 retained word", q, 4'h6);

    // R1/R2: full sweep, each location holds its own word
    for (int a = 0; a < 256; a++)
      access(1'b1, 1'b1, 1'b1, 8'(a), 4'((a * 7 + 3) ^ (a >> 4)), oe, q);
    for (int a = 0; a < 256; a++) begin
      access(1'b0, 1'b1, 1'b1, 8'(a), 4'h0, oe, q);
      check($sformatf("R1/R2 sweep addr %0d", a), q, 4'((a * 7 + 3) ^ (a >> 4)));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule